// File: doc/BRIEF.md
# Timed Unlock Guard for Critical Control Bits

This block lives on an 8-bit special-function-register write bus and owns two control registers, an extended flag register and a watchdog control register. A handful of bits in them are critical: a bandgap select, a power-on reset flag, a watchdog enable, a watchdog restart and a watchdog interrupt flag. Stray code must not be able to change these bits. The other bits in the same two registers behave as ordinary read/write storage.

To change a critical bit, software first writes two key bytes in sequence to a dedicated unlock address: AAh and then 55h. The second key opens a short window that is counted in bus-cycle strobes. While the window is open, one write to either guarded register may change the critical bits. Once that write is accepted, the window shuts. Any other write leaves the critical bit positions exactly as they were and still updates the ordinary bits. The block also provides a read port and exposes each critical bit and the window state as outputs.

Top module: `ta_write_guard`

## Requirements
- R1: After reset the window is closed, the extended flag register reads 00h and the watchdog control register reads 40h. This means the power-on flag is 1 and every other bit is 0.
- R2: A write of AAh to address C7h, followed directly by a write of 55h to C7h, opens the window on the clock edge of the 55h write. `win_open` is 1 from then on.
- R3: The window stays open across cycles in which `cyc_en` is low. It closes on the edge of the third `cyc_en` strobe after it opens.
- R4: A write to a guarded register while the window is open updates the protected positions. These are bit 0 at address 91h, and bits 6, 3, 1 and 0 at address D8h.
- R5: A write to a guarded register while the window is closed leaves every protected bit position unchanged.
- R6: The unprotected bits of both guarded registers take the written value on every write to them, whether or not the window is open.
- R7: After AAh, any write other than 55h to C7h returns the sequence to idle. This includes writes to other addresses, so a later 55h opens nothing.
- R8: A write of AAh to C7h always restarts the sequence at its first step, so AAh, AAh, 55h opens the window.
- R9: An accepted write to a guarded register closes the window on the same edge, so a second guarded write in that window leaves the protected bits unchanged.
- R10: A high `por_set` on a clock edge sets the power-on flag (D8h bit 6). It does so whatever the window state, and it takes priority over a write of 0 to that bit on the same edge.
- R11: `rd_data` returns 00h for address C7h and for unmapped addresses, and returns the full stored byte for 91h and D8h.
- R12: A 55h unlock that completes while the window is open reloads the full three-strobe length. A strobe on that same edge does not shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Bus-cycle strobe that ages the window |
| wr_en | input | 1 | Write strobe, one write per clock |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| por_set | input | 1 | Sets the power-on flag |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data |
| bg_sel | output | 1 | Bandgap select (91h bit 0) |
| por_flag | output | 1 | Power-on reset flag (D8h bit 6) |
| wdt_en | output | 1 | Watchdog enable (D8h bit 1) |
| wdt_kick | output | 1 | Watchdog restart (D8h bit 0) |
| wdt_irq | output | 1 | Watchdog interrupt flag (D8h bit 3) |
| win_open | output | 1 | Unlock window is open |

## Verification
Two pairs of events can fall on the same edge, and both are provoked on purpose.

The first pair is window closing and write acceptance. A guarded write lands on the very cycle of the window's last strobe. The bench judges that the write is still accepted and that the window then shuts. A 55h reload is also driven together with a strobe, and the bench checks that the reload wins.

The second pair is the `por_set` input and an accepted write that clears the power-on flag on the same edge. Here the flag must end at 1.

Random traffic, biased toward the key bytes and the guarded addresses, produces further coincidences. A bench model built from the requirements judges every cycle.

// File: rtl/ta_pkg.sv
package ta_pkg;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_t;

  localparam int unsigned BUS_W = 8;

endpackage

// File: rtl/ta_unlock_fsm.sv
module ta_unlock_fsm
  import ta_pkg::*;
#(
  parameter logic [BUS_W-1:0] ADDR_TA = 8'hC7,
  parameter logic [BUS_W-1:0] KEY1    = 8'hAA,
  parameter logic [BUS_W-1:0] KEY2    = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  output logic             unlock
);

  seq_t state_q, state_d;
  logic ta_hit;

  assign ta_hit = wr_en && (wr_addr == ADDR_TA);
  assign unlock = ta_hit && (wr_data == KEY2) && (state_q == SEQ_ARMED);

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      if (ta_hit && (wr_data == KEY1)) state_d = SEQ_ARMED;
      else                             state_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  // R8
  key_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_TA && wr_data == KEY1) |=> (state_q == SEQ_ARMED));

  // R7
  seq_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(wr_addr == ADDR_TA && wr_data == KEY1)) |=> (state_q == SEQ_IDLE));

endmodule

// File: rtl/ta_window.sv
module ta_window #(
  parameter int unsigned WIN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic close,
  input  logic tick,
  output logic open
);

  localparam int unsigned CW = $clog2(WIN_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign open = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = CW'(WIN_LEN);
    else if (close)         cnt_d = '0;
    else if (tick && open)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  load_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> open);

  // R9
  accept_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close && !load) |=> !open);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !close && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/ta_guard_reg.sv
module ta_guard_reg
  import ta_pkg::*;
#(
  parameter logic [BUS_W-1:0] PMASK   = 8'h01,
  parameter logic [BUS_W-1:0] SMASK   = 8'h00,
  parameter logic [BUS_W-1:0] RST_VAL = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             win_open,
  input  logic             set_in,
  output logic [BUS_W-1:0] q
);

  logic [BUS_W-1:0] q_d;

  for (genvar i = 0; i < BUS_W; i++) begin : g_bit
    logic wr_bit;
    if (PMASK[i]) begin : g_prot
      assign wr_bit = (wr_hit && win_open) ? wr_data[i] : q[i];
    end else begin : g_plain
      assign wr_bit = wr_hit ? wr_data[i] : q[i];
    end
    if (SMASK[i]) begin : g_set
      assign q_d[i] = wr_bit | set_in;
    end else begin : g_noset
      assign q_d[i] = wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_d;
  end

  // R5
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_hit && win_open) && !set_in) |=> ((q & PMASK) == $past(q & PMASK)));

  // R6
  plain_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((q & ~PMASK & ~SMASK) == $past(wr_data & ~PMASK & ~SMASK)));

  // R10
  set_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_in |=> ((q & SMASK) == SMASK));

endmodule

// File: rtl/ta_write_guard.sv
module ta_write_guard
  import ta_pkg::*;
#(
  parameter logic [BUS_W-1:0] ADDR_TA  = 8'hC7,
  parameter logic [BUS_W-1:0] ADDR_XIF = 8'h91,
  parameter logic [BUS_W-1:0] ADDR_WDC = 8'hD8,
  parameter logic [BUS_W-1:0] KEY1     = 8'hAA,
  parameter logic [BUS_W-1:0] KEY2     = 8'h55,
  parameter int unsigned      WIN_LEN  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             por_set,
  input  logic [BUS_W-1:0] rd_addr,
  output logic [BUS_W-1:0] rd_data,
  output logic             bg_sel,
  output logic             por_flag,
  output logic             wdt_en,
  output logic             wdt_kick,
  output logic             wdt_irq,
  output logic             win_open
);

  localparam int unsigned      BIT_BGS  = 0;
  localparam int unsigned      BIT_POR  = 6;
  localparam int unsigned      BIT_IRQ  = 3;
  localparam int unsigned      BIT_EN   = 1;
  localparam int unsigned      BIT_KICK = 0;
  localparam logic [BUS_W-1:0] XIF_PM   = BUS_W'(1) << BIT_BGS;
  localparam logic [BUS_W-1:0] WDC_SM   = BUS_W'(1) << BIT_POR;
  localparam logic [BUS_W-1:0] WDC_PM   = WDC_SM | (BUS_W'(1) << BIT_IRQ)
                                        | (BUS_W'(1) << BIT_EN) | (BUS_W'(1) << BIT_KICK);

  logic             unlock, hit_xif, hit_wdc, accept;
  logic [BUS_W-1:0] xif_q, wdc_q;

  assign hit_xif = wr_en && (wr_addr == ADDR_XIF);
  assign hit_wdc = wr_en && (wr_addr == ADDR_WDC);
  assign accept  = win_open && (hit_xif || hit_wdc);

  ta_unlock_fsm #(.ADDR_TA(ADDR_TA), .KEY1(KEY1), .KEY2(KEY2)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .unlock(unlock)
  );

  ta_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst_n(rst_n), .load(unlock), .close(accept),
    .tick(cyc_en), .open(win_open)
  );

  ta_guard_reg #(.PMASK(XIF_PM), .SMASK('0), .RST_VAL('0)) u_xif (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_xif), .wr_data(wr_data),
    .win_open(win_open), .set_in(1'b0), .q(xif_q)
  );

  ta_guard_reg #(.PMASK(WDC_PM), .SMASK(WDC_SM), .RST_VAL(WDC_SM)) u_wdc (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_wdc), .wr_data(wr_data),
    .win_open(win_open), .set_in(por_set), .q(wdc_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_XIF)      rd_data = xif_q;
    else if (rd_addr == ADDR_WDC) rd_data = wdc_q;
  end

  assign bg_sel   = xif_q[BIT_BGS];
  assign por_flag = wdc_q[BIT_POR];
  assign wdt_en   = wdc_q[BIT_EN];
  assign wdt_kick = wdc_q[BIT_KICK];
  assign wdt_irq  = wdc_q[BIT_IRQ];

  // R4
  open_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wdc && win_open && !por_set) |=> ((wdc_q & WDC_PM) == $past(wr_data & WDC_PM)));

  // R11
  ta_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_TA) |-> (rd_data == '0));

endmodule

// File: tb/ta_write_guard_test.sv
module ta_write_guard_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_en, wr_en, por_set;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic       bg_sel, por_flag, wdt_en, wdt_kick, wdt_irq, win_open;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  logic       m_arm;
  int         m_cnt;
  logic [7:0] m_xif, m_wdc;

  always #10 clk = ~clk;

  ta_write_guard uut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .por_set(por_set),
    .rd_addr(rd_addr), .rd_data(rd_data), .bg_sel(bg_sel),
    .por_flag(por_flag), .wdt_en(wdt_en), .wdt_kick(wdt_kick),
    .wdt_irq(wdt_irq), .win_open(win_open)
  );

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'h91) return m_xif;
    if (a == 8'hD8) return m_wdc;
    return 8'h00;
  endfunction

  function automatic logic [4:0] exp_bits();
    return {m_xif[0], m_wdc[6], m_wdc[1], m_wdc[0], m_wdc[3]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d,
                      input bit c, input bit p, input logic [7:0] r, input string tag);
    bit open_now, acc, unl;
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; cyc_en = c; por_set = p; rd_addr = r;
    open_now = (m_cnt != 0);
    acc = w && open_now && (a == 8'h91 || a == 8'hD8);
    unl = w && a == 8'hC7 && d == 8'h55 && m_arm;
    if (w && a == 8'h91) m_xif = (d & 8'hFE) | ((open_now ? d : m_xif) & 8'h01);
    if (w && a == 8'hD8) m_wdc = (d & 8'hB4) | ((open_now ? d : m_wdc) & 8'h4B);
    if (p) m_wdc[6] = 1'b1;
    if (unl)                 m_cnt = 3;
    else if (acc)            m_cnt = 0;
    else if (c && open_now)  m_cnt = m_cnt - 1;
    if (w) m_arm = (a == 8'hC7 && d == 8'hAA);
    @(posedge clk);
    #3;
    chk(tag, 32'(win_open), 32'(m_cnt != 0));
    chk(tag, 32'({bg_sel, por_flag, wdt_en, wdt_kick, wdt_irq}), 32'(exp_bits()));
    chk(tag, 32'(rd_data), 32'(exp_rd(r)));
    wr_en = 1'b0;
  endtask

  task automatic unlock(input string tag);
    step(1, 8'hC7, 8'hAA, 1, 0, 8'hC7, tag);
    step(1, 8'hC7, 8'h55, 1, 0, 8'hC7, tag);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cyc_en = 0; wr_en = 0; por_set = 0;
    wr_addr = 0; wr_data = 0; rd_addr = 8'hD8;
    m_arm = 0; m_cnt = 0; m_xif = 8'h00; m_wdc = 8'h40;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #3;
    chk("R1", 32'(win_open), 0);
    chk("R1", 32'(rd_data), 32'h40);
    @(negedge clk);
    rst_n = 1'b1;
    rd_addr = 8'h91;
    #1;
    chk("R1", 32'(rd_data), 32'h00);
    chk("R1", 32'({bg_sel, por_flag, wdt_en, wdt_kick, wdt_irq}), 32'b01000);

    // R2: unlock opens window
    unlock("R2");
    chk("R2", 32'(win_open), 1);
    // R3: no strobe keeps it open, third strobe closes
    step(0, 0, 0, 0, 0, 8'hD8, "R3");
    step(0, 0, 0, 0, 0, 8'hD8, "R3");
    step(0, 0, 0, 1, 0, 8'hD8, "R3");
    step(0, 0, 0, 1, 0, 8'hD8, "R3");
    chk("R3", 32'(win_open), 1);
    step(0, 0, 0, 1, 0, 8'hD8, "R3");
    chk("R3", 32'(win_open), 0);

    // R4: write inside window
    unlock("R4");
    step(1, 8'hD8, 8'h0B, 1, 0, 8'hD8, "R4");
    chk("R4", 32'({por_flag, wdt_irq, wdt_en, wdt_kick}), 32'b0111);
    // R9: second write in same unlock dropped
    step(1, 8'hD8, 8'h00, 1, 0, 8'hD8, "R9");
    chk("R9", 32'(wdt_en), 1);
    // R5 / R6: write outside window
    step(1, 8'h91, 8'hFF, 1, 0, 8'h91, "R5");
    chk("R5", 32'(bg_sel), 0);
    chk("R6", 32'(rd_data), 32'hFE);

    // R7: broken sequences
    step(1, 8'hC7, 8'hAA, 1, 0, 8'hC7, "R7");
    step(1, 8'hC7, 8'h12, 1, 0, 8'hC7, "R7");
    step(1, 8'hC7, 8'h55, 1, 0, 8'hC7, "R7");
    chk("R7", 32'(win_open), 0);
    step(1, 8'hC7, 8'hAA, 1, 0, 8'hC7, "R7");
    step(1, 8'h91, 8'h00, 1, 0, 8'hC7, "R7");
    step(1, 8'hC7, 8'h55, 1, 0, 8'hC7, "R7");
    chk("R7", 32'(win_open), 0);

    // R8: AA restarts
    step(1, 8'hC7, 8'hAA, 1, 0, 8'hC7, "R8");
    step(1, 8'hC7, 8'hAA, 1, 0, 8'hC7, "R8");
    step(1, 8'hC7, 8'h55, 1, 0, 8'hC7, "R8");
    chk("R8", 32'(win_open), 1);
    // guarded write on the final strobe is still accepted (R9)
    step(0, 0, 0, 1, 0, 8'h91, "R9");
    step(0, 0, 0, 1, 0, 8'h91, "R9");
    step(1, 8'h91, 8'h01, 1, 0, 8'h91, "R9");
    chk("R9", 32'(bg_sel), 1);
    chk("R9", 32'(win_open), 0);

    // R10: por_set beats a clearing write on the same edge
    unlock("R10");
    step(1, 8'hD8, 8'h00, 1, 1, 8'hD8, "R10");
    chk("R10", 32'(por_flag), 1);
    chk("R10", 32'(wdt_en), 0);
    unlock("R10");
    step(1, 8'hD8, 8'h00, 1, 0, 8'hD8, "R10");
    chk("R10", 32'(por_flag), 0);
    step(0, 0, 0, 0, 1, 8'hD8, "R10");
    chk("R10", 32'(por_flag), 1);

    // R11: read port
    step(1, 8'hC7, 8'hAA, 0, 0, 8'hC7, "R11");
    chk("R11", 32'(rd_data), 0);
    step(0, 0, 0, 0, 0, 8'h10, "R11");
    chk("R11", 32'(rd_data), 0);

    // R12: reload during open window with simultaneous strobe
    unlock("R12");
    step(0, 0, 0, 1, 0, 8'hD8, "R12");
    step(1, 8'hC7, 8'hAA, 1, 0, 8'hD8, "R12");
    step(1, 8'hC7, 8'h55, 1, 0, 8'hD8, "R12");
    step(0, 0, 0, 1, 0, 8'hD8, "R12");
    step(0, 0, 0, 1, 0, 8'hD8, "R12");
    chk("R12", 32'(win_open), 1);
    step(0, 0, 0, 1, 0, 8'hD8, "R12");
    chk("R12", 32'(win_open), 0);

    // random mix, checked against the model every cycle (R5)
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a, d, r;
      int unsigned k;
      k = $urandom_range(0, 9);
      a = (k < 4) ? 8'hC7 : (k < 6) ? 8'h91 : (k < 8) ? 8'hD8 : 8'($urandom);
      k = $urandom_range(0, 5);
      d = (k < 2) ? 8'hAA : (k < 4) ? 8'h55 : 8'($urandom);
      k = $urandom_range(0, 3);
      r = (k == 0) ? 8'h91 : (k == 1) ? 8'hD8 : (k == 2) ? 8'hC7 : 8'($urandom);
      step($urandom_range(0, 3) != 0, a, d, $urandom_range(0, 2) != 0,
           $urandom_range(0, 31) == 0, r, "R5");
    end

    done = 1'b1;
    finish_run();
  end

endmodule